// File: doc/BRIEF.md
# Serial Line Register Interface

This block is the host-side register face of a multi-line asynchronous terminal port. Every line owns four 16-bit registers: a receive status word, a receive buffer, a transmit status word and a transmit buffer. The host reaches them through a simple synchronous bus with one access per cycle. Read data is combinational. Any side effect of an access takes place at the clock edge that ends the access. Byte writes are supported through a byte flag, and address bit 0 picks the odd byte.

Towards the line side, each channel talks to an external serializer. Received characters arrive as a one-cycle strobe that carries a character and a break flag. Characters to send leave on a ready/valid handshake. The serializer then reports the end of the character with a one-cycle completion pulse.

Each line holds two small state machines:
- The receive machine has the states EMPTY and FULL. A character strobe moves it from EMPTY to FULL, or keeps it in FULL and marks an overrun. A read of the buffer moves it from FULL back to EMPTY.
- The transmit machine has the states IDLE, OFFER and WAIT. A buffer write moves it from IDLE to OFFER. Acceptance by the serializer moves it from OFFER to WAIT. The completion pulse moves it from WAIT back to IDLE.

Receive done is the FULL state. Transmit done is the IDLE state.

Top module: `sline_regs`

## Requirements
- R1: The register window starts at parameter BASE and spans 8 bytes per line. The line is (address − BASE) >> 3. Address bits 2:1 select the register: 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer. An access outside the window changes nothing and reads as zero.
- R2: Receive status shows done in bit 7 and interrupt enable in bit 6. All its other bits read 0, and the whole word is 0 after reset.
- R3: The receive buffer reads error in bit 15, overrun in bit 14 and break in bit 13, with the character in bits 7:0. A normal character arriving while done is clear is stored with all three flags clear and sets done.
- R4: A read of the receive buffer clears receive done and withdraws that line's receive interrupt.
- R5: A character that arrives while receive done is still set replaces the buffer with the error and overrun flags set. Done stays set.
- R6: A received break is stored with error and break set and a zero character.
- R7: In both status words, writing enable as 0 withdraws the line's request. Writing enable as 1 while done is set and enable was clear raises a request. A character arrival or a transmit completion raises a request when enable is set.
- R8: A byte write to the odd byte of any status register or of the transmit buffer has no effect. A byte write to the even byte acts like a word write of the low byte.
- R9: A transmit-buffer write while done is set stores bits 7:0, clears done, clears the transmit request and offers the character with tx_valid until tx_ready. Done returns on the completion pulse. A transmit-buffer write while done is clear is dropped.
- R10: Transmit status carries a writable loop bit 2 (driving tx_loop) and a writable break bit 0 (driving tx_brk), besides done and enable. It reads 0x0080 after reset.
- R11: Writes to the receive buffer have no effect, and the transmit buffer reads as zero.
- R12: A character arriving in the same cycle as a read of the receive buffer is stored without overrun, and done stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte write, with bus_addr[0] picking the odd byte |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| rx_valid | input | NUM_LINES | Per-line character-arrival strobe |
| rx_break | input | NUM_LINES | Arrival is a break condition |
| rx_char | input | 8*NUM_LINES | Received characters, line i at bits 8i+7:8i |
| tx_valid | output | NUM_LINES | Character offered to the serializer |
| tx_char | output | 8*NUM_LINES | Character being offered or sent |
| tx_ready | input | NUM_LINES | Serializer accepts the offer |
| tx_done | input | NUM_LINES | One-cycle completion pulse |
| tx_brk | output | NUM_LINES | Host break-send control bit |
| tx_loop | output | NUM_LINES | Host maintenance-loop control bit |
| rx_irq | output | NUM_LINES | Receive interrupt requests |
| tx_irq | output | NUM_LINES | Transmit interrupt requests |

## Verification
The bench builds the block with NUM_LINES = 4, ADDR_W = 12 and BASE = 0x100. With these values the top line (line 3) is reachable, as are an address just below the window (0x0F8) and one just past it (0x120). Both window edges are therefore exercised, together with decode of every line. Four lines let overrun, break, interrupt and control-bit cases run on separate lines, so one line's state cannot hide a fault in another's.

// File: rtl/sline_pkg.sv
package sline_pkg;
    localparam int WORD_W = 16;
    localparam int CHAR_W = 8;

    // Register select in address bits 2:1
    typedef enum logic [1:0] {
        REG_RXSTAT = 2'd0,
        REG_RXBUF  = 2'd1,
        REG_TXSTAT = 2'd2,
        REG_TXBUF  = 2'd3
    } reg_sel_e;

    // Status bit positions shared by both status words
    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_LOOP = 2;
    localparam int BIT_TBRK = 0;

    // Receive buffer flag positions
    localparam int BIT_ERR  = 15;
    localparam int BIT_OVR  = 14;
    localparam int BIT_RBRK = 13;

    typedef enum logic {
        RX_EMPTY,
        RX_FULL
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_OFFER,
        TX_WAIT
    } tx_state_e;
endpackage

// File: rtl/sline_decode.sv
module sline_decode
    import sline_pkg::*;
#(
    parameter int          NUM_LINES = 4,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE      = 'h100,
    localparam int         LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_byte,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic                 hit,
    output logic [LINE_W-1:0]    line_idx,
    output reg_sel_e             sel,
    output logic [NUM_LINES-1:0] wr_rxstat,
    output logic [NUM_LINES-1:0] rd_rxbuf,
    output logic [NUM_LINES-1:0] wr_txstat,
    output logic [NUM_LINES-1:0] wr_txbuf
);
    localparam int SPAN = NUM_LINES * 8;

    logic [ADDR_W-1:0] offset;
    logic              low_lane_ok;

    always_comb begin
        offset      = bus_addr - ADDR_W'(BASE);
        hit         = bus_req && (bus_addr >= ADDR_W'(BASE)) && (offset < ADDR_W'(SPAN));
        line_idx    = offset[LINE_W+2:3];
        sel         = reg_sel_e'(bus_addr[2:1]);
        low_lane_ok = !bus_byte || !bus_addr[0];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_strobe
        logic match;
        assign match        = hit && (line_idx == LINE_W'(g));
        assign wr_rxstat[g] = match && bus_we && (sel == REG_RXSTAT) && low_lane_ok;
        assign rd_rxbuf[g]  = match && !bus_we && (sel == REG_RXBUF);
        assign wr_txstat[g] = match && bus_we && (sel == REG_TXSTAT) && low_lane_ok;
        assign wr_txbuf[g]  = match && bus_we && (sel == REG_TXBUF) && low_lane_ok;
    end

    // At most one strobe for one bus access (R1)
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_rxstat, rd_rxbuf, wr_txstat, wr_txbuf}));

    // Outside the window nothing is touched (R1)
    p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ({wr_rxstat, rd_rxbuf, wr_txstat, wr_txbuf} == '0));

    // Odd-byte writes reach no register (R8)
    p_odd_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_byte && bus_addr[0]) |->
            ({wr_rxstat, wr_txstat, wr_txbuf} == '0));
endmodule

// File: rtl/sline_rx_line.sv
module sline_rx_line
    import sline_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              rd_buf,
    input  logic              wdata_ie,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_char,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] buf_o,
    output logic              irq_o
);
    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] buf_q, buf_d;
    logic              ie_q, ie_d;
    logic              irq_q, irq_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            buf_q   <= '0;
            ie_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
            ie_q    <= ie_d;
            irq_q   <= irq_d;
        end
    end

    // Next state: enable write, buffer read, then arrival (arrival wins)
    always_comb begin
        state_d = state_q;
        buf_d   = buf_q;
        ie_d    = ie_q;
        irq_d   = irq_q;

        if (wr_stat) begin
            ie_d = wdata_ie;
            if (!wdata_ie)
                irq_d = 1'b0;
            else if ((state_q == RX_FULL) && !ie_q)
                irq_d = 1'b1;
        end

        unique case (state_q)
            RX_EMPTY: begin
                if (rx_valid) begin
                    state_d = RX_FULL;
                    buf_d   = '0;
                    if (rx_break) begin
                        buf_d[BIT_ERR]  = 1'b1;
                        buf_d[BIT_RBRK] = 1'b1;
                    end else begin
                        buf_d[CHAR_W-1:0] = rx_char;
                    end
                    if (ie_d)
                        irq_d = 1'b1;
                end
            end
            RX_FULL: begin
                if (rd_buf) begin
                    state_d = RX_EMPTY;
                    irq_d   = 1'b0;
                end
                if (rx_valid) begin
                    state_d = RX_FULL;
                    buf_d   = '0;
                    if (rx_break) begin
                        buf_d[BIT_ERR]  = 1'b1;
                        buf_d[BIT_RBRK] = 1'b1;
                    end else begin
                        buf_d[CHAR_W-1:0] = rx_char;
                    end
                    if (!rd_buf) begin
                        buf_d[BIT_ERR] = 1'b1;
                        buf_d[BIT_OVR] = 1'b1;
                    end
                    if (ie_d)
                        irq_d = 1'b1;
                end
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        stat_o           = '0;
        stat_o[BIT_DONE] = (state_q == RX_FULL);
        stat_o[BIT_IE]   = ie_q;
        buf_o            = buf_q;
        irq_o            = irq_q;
    end

    p_rd_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !rx_valid) |=> (!stat_o[BIT_DONE] && !irq_o));

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && stat_o[BIT_DONE] && !rd_buf) |=>
            (buf_o[BIT_ERR] && buf_o[BIT_OVR] && stat_o[BIT_DONE]));

    p_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |=>
            (buf_o[BIT_ERR] && buf_o[BIT_RBRK] && (buf_o[CHAR_W-1:0] == '0)));

    p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> stat_o[BIT_IE]);

    p_same_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rd_buf) |=> (!buf_o[BIT_OVR] && stat_o[BIT_DONE]));
endmodule

// File: rtl/sline_tx_line.sv
module sline_tx_line
    import sline_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_buf,
    input  logic [CHAR_W-1:0] wdata_lo,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_brk,
    output logic              tx_loop,
    output logic [WORD_W-1:0] stat_o,
    output logic              irq_o
);
    tx_state_e         state_q, state_d;
    logic [CHAR_W-1:0] buf_q, buf_d;
    logic              ie_q, ie_d;
    logic              irq_q, irq_d;
    logic              loop_q, loop_d;
    logic              brk_q, brk_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            buf_q   <= '0;
            ie_q    <= 1'b0;
            irq_q   <= 1'b0;
            loop_q  <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
            ie_q    <= ie_d;
            irq_q   <= irq_d;
            loop_q  <= loop_d;
            brk_q   <= brk_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        buf_d   = buf_q;
        ie_d    = ie_q;
        irq_d   = irq_q;
        loop_d  = loop_q;
        brk_d   = brk_q;

        if (wr_stat) begin
            ie_d   = wdata_lo[BIT_IE];
            loop_d = wdata_lo[BIT_LOOP];
            brk_d  = wdata_lo[BIT_TBRK];
            if (!wdata_lo[BIT_IE])
                irq_d = 1'b0;
            else if ((state_q == TX_IDLE) && !ie_q)
                irq_d = 1'b1;
        end

        unique case (state_q)
            TX_IDLE: begin
                if (wr_buf) begin
                    buf_d   = wdata_lo;
                    state_d = TX_OFFER;
                    irq_d   = 1'b0;
                end
            end
            TX_OFFER: begin
                if (tx_ready)
                    state_d = TX_WAIT;
            end
            TX_WAIT: begin
                if (tx_done) begin
                    state_d = TX_IDLE;
                    if (ie_d)
                        irq_d = 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid         = (state_q == TX_OFFER);
        tx_char          = buf_q;
        tx_brk           = brk_q;
        tx_loop          = loop_q;
        stat_o           = '0;
        stat_o[BIT_DONE] = (state_q == TX_IDLE);
        stat_o[BIT_IE]   = ie_q;
        stat_o[BIT_LOOP] = loop_q;
        stat_o[BIT_TBRK] = brk_q;
        irq_o            = irq_q;
    end

    p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_char)));

    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && stat_o[BIT_DONE]) |=> (tx_valid && !stat_o[BIT_DONE] && !irq_o));

    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && !stat_o[BIT_DONE]) |=> $stable(tx_char));

    p_finish_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TX_WAIT) && tx_done && ie_q && !wr_stat) |=>
            (irq_o && stat_o[BIT_DONE]));

    p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> stat_o[BIT_IE]);
endmodule

// File: rtl/sline_regs.sv
module sline_regs
    import sline_pkg::*;
#(
    parameter int          NUM_LINES = 4,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE      = 'h100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic                        bus_byte,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    input  logic [NUM_LINES-1:0]        rx_valid,
    input  logic [NUM_LINES-1:0]        rx_break,
    input  logic [8*NUM_LINES-1:0]      rx_char,
    output logic [NUM_LINES-1:0]        tx_valid,
    output logic [8*NUM_LINES-1:0]      tx_char,
    input  logic [NUM_LINES-1:0]        tx_ready,
    input  logic [NUM_LINES-1:0]        tx_done,
    output logic [NUM_LINES-1:0]        tx_brk,
    output logic [NUM_LINES-1:0]        tx_loop,
    output logic [NUM_LINES-1:0]        rx_irq,
    output logic [NUM_LINES-1:0]        tx_irq
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic                 hit;
    logic [LINE_W-1:0]    line_idx;
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] wr_rxstat, rd_rxbuf, wr_txstat, wr_txbuf;
    logic [WORD_W-1:0]    rx_stat [NUM_LINES];
    logic [WORD_W-1:0]    rx_buf  [NUM_LINES];
    logic [WORD_W-1:0]    tx_stat [NUM_LINES];
    logic                 unused_hi;

    // Upper write lane is never stored: odd-byte writes are ignored
    assign unused_hi = ^bus_wdata[15:8];

    sline_decode #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .BASE      (BASE)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .hit       (hit),
        .line_idx  (line_idx),
        .sel       (sel),
        .wr_rxstat (wr_rxstat),
        .rd_rxbuf  (rd_rxbuf),
        .wr_txstat (wr_txstat),
        .wr_txbuf  (wr_txbuf)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sline_rx_line u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stat  (wr_rxstat[g]),
            .rd_buf   (rd_rxbuf[g]),
            .wdata_ie (bus_wdata[BIT_IE]),
            .rx_valid (rx_valid[g]),
            .rx_break (rx_break[g]),
            .rx_char  (rx_char[g*CHAR_W +: CHAR_W]),
            .stat_o   (rx_stat[g]),
            .buf_o    (rx_buf[g]),
            .irq_o    (rx_irq[g])
        );

        sline_tx_line u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stat  (wr_txstat[g]),
            .wr_buf   (wr_txbuf[g]),
            .wdata_lo (bus_wdata[CHAR_W-1:0]),
            .tx_ready (tx_ready[g]),
            .tx_done  (tx_done[g]),
            .tx_valid (tx_valid[g]),
            .tx_char  (tx_char[g*CHAR_W +: CHAR_W]),
            .tx_brk   (tx_brk[g]),
            .tx_loop  (tx_loop[g]),
            .stat_o   (tx_stat[g]),
            .irq_o    (tx_irq[g])
        );
    end

    // Read mux; the transmit buffer and misses read zero
    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_we) begin
            unique case (sel)
                REG_RXSTAT: bus_rdata = rx_stat[line_idx];
                REG_RXBUF:  bus_rdata = rx_buf[line_idx];
                REG_TXSTAT: bus_rdata = tx_stat[line_idx];
                REG_TXBUF:  bus_rdata = '0;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // Misses read as zero (R1)
    p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));
endmodule

// File: tb/sline_regs_bench.sv
module sline_regs_bench;
    localparam int NL = 4;
    localparam int AW = 12;

    localparam logic [1:0] OP_RD = 2'd0;
    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_WB = 2'd2;
    localparam logic [1:0] OP_RX = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 12'h100, 16'h0000, 16'h0000, 8'd2},  // R2 reset receive status
        '{OP_RD, 12'h104, 16'h0000, 16'h0080, 8'd10}, // R10 reset transmit status
        '{OP_RX, 12'h000, 16'h0041, 16'h0000, 8'd3},
        '{OP_RD, 12'h100, 16'h0000, 16'h0080, 8'd2},  // R2 done visible
        '{OP_RD, 12'h102, 16'h0000, 16'h0041, 8'd3},  // R3 clean character
        '{OP_RD, 12'h100, 16'h0000, 16'h0000, 8'd4},  // R4 done cleared
        '{OP_RX, 12'h001, 16'h0055, 16'h0000, 8'd5},
        '{OP_RX, 12'h001, 16'h0066, 16'h0000, 8'd5},
        '{OP_RD, 12'h10A, 16'h0000, 16'hC066, 8'd5},  // R5 overrun flags
        '{OP_RD, 12'h108, 16'h0000, 16'h0000, 8'd4},  // R4
        '{OP_RX, 12'h002, 16'h0100, 16'h0000, 8'd6},
        '{OP_RD, 12'h112, 16'h0000, 16'hA000, 8'd6},  // R6 break
        '{OP_WR, 12'h118, 16'hFFFF, 16'h0000, 8'd2},
        '{OP_RD, 12'h118, 16'h0000, 16'h0040, 8'd2},  // R2 only enable writable
        '{OP_WB, 12'h119, 16'h0000, 16'h0000, 8'd8},
        '{OP_RD, 12'h118, 16'h0000, 16'h0040, 8'd8},  // R8 odd byte ignored
        '{OP_WB, 12'h118, 16'h0000, 16'h0000, 8'd8},
        '{OP_RD, 12'h118, 16'h0000, 16'h0000, 8'd8},  // R8 even byte acts
        '{OP_WR, 12'h11C, 16'hFFFF, 16'h0000, 8'd10},
        '{OP_RD, 12'h11C, 16'h0000, 16'h00C5, 8'd10}, // R10 writable bits
        '{OP_WB, 12'h11D, 16'h0000, 16'h0000, 8'd8},
        '{OP_RD, 12'h11C, 16'h0000, 16'h00C5, 8'd8},  // R8
        '{OP_WR, 12'h11C, 16'h0000, 16'h0000, 8'd10},
        '{OP_RD, 12'h11C, 16'h0000, 16'h0080, 8'd10}, // R10
        '{OP_WR, 12'h10A, 16'h1234, 16'h0000, 8'd11},
        '{OP_RD, 12'h10A, 16'h0000, 16'hC066, 8'd11}, // R11 buffer write ignored
        '{OP_RD, 12'h106, 16'h0000, 16'h0000, 8'd11}, // R11 tx buffer reads zero
        '{OP_WR, 12'h120, 16'h0040, 16'h0000, 8'd1},
        '{OP_RD, 12'h120, 16'h0000, 16'h0000, 8'd1},  // R1 past window
        '{OP_RD, 12'h100, 16'h0000, 16'h0000, 8'd1},  // R1 line 0 untouched
        '{OP_RD, 12'h0F8, 16'h0000, 16'h0000, 8'd1}   // R1 below window
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [NL-1:0]   rx_valid = '0, rx_break = '0;
    logic [8*NL-1:0] rx_char = '0;
    logic [NL-1:0]   tx_valid;
    logic [8*NL-1:0] tx_char;
    logic [NL-1:0]   tx_ready = '0, tx_done = '0;
    logic [NL-1:0]   tx_brk, tx_loop, rx_irq, tx_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sline_regs #(.NUM_LINES(NL), .ADDR_W(AW), .BASE('h100)) u_sline_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_char(rx_char),
        .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_brk(tx_brk), .tx_loop(tx_loop),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_byte = b; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] got);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] got;
        rd(a, got);
        chk(tag, got, exp);
    endtask

    task automatic rx_in(input int l, input logic [7:0] c, input logic brk);
        @(negedge clk);
        rx_valid[l] = 1'b1; rx_break[l] = brk; rx_char[l*8 +: 8] = c;
        @(negedge clk);
        rx_valid = '0; rx_break = '0;
    endtask

    task automatic pulse_ready(input int l);
        @(negedge clk); tx_ready[l] = 1'b1;
        @(negedge clk); tx_ready = '0;
    endtask

    task automatic pulse_done(input int l);
        @(negedge clk); tx_done[l] = 1'b1;
        @(negedge clk); tx_done = '0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_RD: rd_chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
                OP_WR: wr(VEC[i].addr, VEC[i].data, 1'b0);
                OP_WB: wr(VEC[i].addr, VEC[i].data, 1'b1);
                OP_RX: rx_in(int'(VEC[i].addr), VEC[i].data[7:0], VEC[i].data[8]);
                default: ;
            endcase
        end

        // Transmit path, line 0
        wr(12'h106, 16'h01AB, 1'b0);
        #1 chk("R9 valid after write", 16'(tx_valid[0]), 16'h1);
        chk("R9 char low byte", 16'(tx_char[7:0]), 16'h00AB);
        rd_chk("R9 done cleared", 12'h104, 16'h0000);
        wr(12'h106, 16'h0022, 1'b0);
        #1 chk("R9 busy write dropped", 16'(tx_char[7:0]), 16'h00AB);
        pulse_ready(0);
        #1 chk("R9 offer withdrawn", 16'(tx_valid[0]), 16'h0);
        wr(12'h104, 16'h0040, 1'b0);
        #1 chk("R7 no request while busy", 16'(tx_irq[0]), 16'h0);
        pulse_done(0);
        #1 chk("R7 completion request", 16'(tx_irq[0]), 16'h1);
        rd_chk("R9 done back", 12'h104, 16'h00C0);
        wr(12'h104, 16'h0000, 1'b0);
        #1 chk("R7 enable off withdraws", 16'(tx_irq[0]), 16'h0);
        wr(12'h104, 16'h0040, 1'b0);
        #1 chk("R7 enable on while done", 16'(tx_irq[0]), 16'h1);
        wr(12'h107, 16'hFFFF, 1'b1);
        #1 chk("R8 odd byte to tx buffer", 16'(tx_valid[0]), 16'h0);
        wr(12'h106, 16'h0033, 1'b0);
        #1 chk("R9 write clears request", 16'(tx_irq[0]), 16'h0);
        chk("R9 second char", 16'(tx_char[7:0]), 16'h0033);
        pulse_ready(0);
        pulse_done(0);
        #1 chk("R7 second completion", 16'(tx_irq[0]), 16'h1);
        wr(12'h104, 16'h0000, 1'b0);

        // Control bits, line 3
        wr(12'h11C, 16'h0005, 1'b0);
        #1 chk("R10 loop out", 16'(tx_loop[3]), 16'h1);
        chk("R10 break out", 16'(tx_brk[3]), 16'h1);
        wr(12'h11C, 16'h0000, 1'b0);
        #1 chk("R10 controls cleared", 16'({tx_loop[3], tx_brk[3]}), 16'h0);

        // Receive requests, line 0
        wr(12'h100, 16'h0040, 1'b0);
        rx_in(0, 8'h10, 1'b0);
        #1 chk("R7 arrival request", 16'(rx_irq[0]), 16'h1);
        rd_chk("R3 buffer", 12'h102, 16'h0010);
        #1 chk("R4 read withdraws", 16'(rx_irq[0]), 16'h0);
        rx_in(0, 8'h11, 1'b0);
        wr(12'h100, 16'h0000, 1'b0);
        #1 chk("R7 disable withdraws", 16'(rx_irq[0]), 16'h0);
        rd_chk("R7 done kept", 12'h100, 16'h0080);
        wr(12'h100, 16'h0040, 1'b0);
        #1 chk("R7 enable with done", 16'(rx_irq[0]), 16'h1);
        rd_chk("R4 read", 12'h102, 16'h0011);
        #1 chk("R4 request gone", 16'(rx_irq[0]), 16'h0);

        // Arrival in the read cycle, line 1
        rx_in(1, 8'h44, 1'b0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h10A;
        rx_valid[1] = 1'b1; rx_char[15:8] = 8'h45;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; rx_valid = '0;
        chk("R12 read returns old", got, 16'h0044);
        rd_chk("R12 done stays", 12'h108, 16'h0080);
        rd_chk("R12 no overrun", 12'h10A, 16'h0045);

        // Reset in mid-run
        wr(12'h106, 16'h0077, 1'b0);
        wr(12'h100, 16'h0040, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        #1 chk("R10 offer dropped by reset", 16'(tx_valid[0]), 16'h0);
        rd_chk("R10 tx status after reset", 12'h104, 16'h0080);
        rd_chk("R2 rx status after reset", 12'h100, 16'h0000);
        rd_chk("R3 buffer after reset", 12'h102, 16'h0000);

        finish_run();
    end
endmodule